// File: doc/BRIEF.md
# Command Packet Queue Front End

This block lets a processor send short and long command packets over a serial display link, and collect the words that come back. The processor first writes the payload of a long packet as 32-bit words into a write payload FIFO, with bytes packed little-endian and the last partial word zero-padded in its upper bytes. It then writes the 32-bit packet header. That header write completes the packet and queues it in a command FIFO, and this is what starts transmission.

A transmitter takes headers from the command FIFO. For each one it emits the header word and then exactly as many payload words as the header's word count needs. The words go out on a valid/ready word stream that stands in for the serial link. With each packet it also gives a low-power/high-speed choice and an acknowledge-request flag, both taken from a configuration register. Response words from the link are stored in a read payload FIFO, and the processor drains that FIFO through the payload register. A single status word reports the full and empty flags of all three FIFOs, a read-in-progress flag and a sticky overflow flag.

Register offsets (byte address): configuration 0x0, header 0x4, payload 0x8 (a write pushes to the write payload FIFO, a read pops the read payload FIFO), status 0xC.

Top module: `cpf_cmd_if`

## Requirements
- R1: After reset, status reads 0x15 (all three FIFOs empty, nothing else set), configuration reads 0, and lk_valid is low.
- R2: Status bit positions: 0 command FIFO empty, 1 command FIFO full, 2 write payload FIFO empty, 3 write payload FIFO full, 4 read payload FIFO empty, 5 read payload FIFO full, 6 read in progress, 7 sticky overflow. All other bits read 0.
- R3: Queued payload words produce nothing on the link until a header is written. The header word then goes out first, followed by the payload words in the order they were written.
- R4: While lk_valid is high and lk_ready is low, lk_valid, lk_data and lk_last stay unchanged into the next cycle.
- R5: A header whose data type low nibble (bits 3:0) is 0x9 is a long packet. Its byte count is header bits 23:8. Exactly ceil(count/4) payload words follow the header, and lk_last marks the final word; a count of 0 sends the header alone. A short packet sends only its header, with lk_last set, and pops no payload word.
- R6: A header write while the command FIFO is full, or a payload write while the write payload FIFO is full, is discarded and sets status bit 7. Bit 7 stays set until the status register is written with bit 7 high.
- R7: The writable configuration bits are 1, 8–14, 16–19 and 24; all other bits read 0. lk_lp for a packet equals the configuration bit picked by its data type (bits 5:0): 0x03→8, 0x13→9, 0x23→10, 0x04→11, 0x14→12, 0x24→13, 0x29→14, 0x05→16, 0x15→17, 0x06→18, 0x39→19, 0x37→24, and 0 for any other type.
- R8: lk_ack equals configuration bit 1 as it stood when the packet's header left the command FIFO, and it is held for every word of that packet.
- R9: Status bit 6 sets when the header of a read request (data type 0x04, 0x14, 0x24 or 0x06) is accepted on the link. It clears only when a response word flagged rsp_last is stored in the read payload FIFO.
- R10: Reading the payload register pops the read payload FIFO oldest word first. A read while that FIFO is empty returns 0. rsp_ready is low while the read payload FIFO is full, and no response word is stored then.
- R11: Once every queued packet has been fully sent, status bits 0 and 2 both read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the payload offset) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| lk_valid | output | 1 | Link word valid |
| lk_ready | input | 1 | Link accepts the word |
| lk_data | output | 32 | Link word: header, then payload |
| lk_last | output | 1 | Final word of the packet |
| lk_lp | output | 1 | Send this packet in low-power mode |
| lk_ack | output | 1 | Request an acknowledge for this packet |
| rsp_valid | input | 1 | Response word valid |
| rsp_ready | output | 1 | Read payload FIFO can take a word |
| rsp_data | input | 32 | Response word, lowest byte first |
| rsp_last | input | 1 | Final word of the response |

## Verification
The hardest state to reach from the ports is a full command FIFO. The transmitter always holds one header of its own, so filling the FIFO takes the link stalled and one more header write than the FIFO depth, and a further write is needed to hit the overflow drop. The bench holds lk_ready low, writes depth plus two headers, and then checks that exactly depth plus one packets come out once the link is released. A second hard case is a full read payload FIFO while a read is still open. Here a final response word is offered but refused, and the bench checks that the read-in-progress flag does not clear until that word is offered again and accepted after draining. Random long and short packets with random lengths, configuration values and link back-pressure cover the framing and the mode flags.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   localparam int WORD_W = 32;
   localparam int WC_W   = 16;
   localparam int REM_W  = WC_W - 1;

   localparam logic [3:0] OFS_CFG  = 4'h0;
   localparam logic [3:0] OFS_HDR  = 4'h4;
   localparam logic [3:0] OFS_PLD  = 4'h8;
   localparam logic [3:0] OFS_STAT = 4'hC;

   localparam int ST_OVF = 7;

   localparam logic [WORD_W-1:0] CFG_MASK = 32'h010F_7F02;
   localparam int CFG_ACK = 1;

   typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PLD} tx_state_e;

   function automatic logic lp_pick(input logic [5:0] dt, input logic [WORD_W-1:0] cfg);
      case (dt)
         6'h03:   return cfg[8];
         6'h13:   return cfg[9];
         6'h23:   return cfg[10];
         6'h04:   return cfg[11];
         6'h14:   return cfg[12];
         6'h24:   return cfg[13];
         6'h29:   return cfg[14];
         6'h05:   return cfg[16];
         6'h15:   return cfg[17];
         6'h06:   return cfg[18];
         6'h39:   return cfg[19];
         6'h37:   return cfg[24];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_long(input logic [5:0] dt);
      return dt[3:0] == 4'h9;
   endfunction

   function automatic logic is_read(input logic [5:0] dt);
      return (dt == 6'h04) || (dt == 6'h14) || (dt == 6'h24) || (dt == 6'h06);
   endfunction
endpackage

// File: rtl/cpf_fifo.sv
module cpf_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   initial begin
      assert (DEPTH >= 1) else $error("cpf_fifo: DEPTH must be at least 1");
      assert (W >= 1) else $error("cpf_fifo: W must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] data_q;
         logic         held_q;
         always_ff @(posedge clk) begin
            if (!rst_n) held_q <= 1'b0;
            else if (push) held_q <= 1'b1;
            else if (pop) held_q <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) data_q <= din;
         end
         assign dout  = data_q;
         assign empty = !held_q;
         assign full  = held_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp_q, rp_q;
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (pop)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
               cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp_q] <= din;
         end
         assign dout  = mem[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CNT_W'(DEPTH));
      end
   endgenerate

   // R6: callers must discard writes that arrive while full
   p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));
   // R5: the transmitter never takes a word that is not there
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));
endmodule

// File: rtl/cpf_tx_engine.sv
module cpf_tx_engine import cpf_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] cfg,
   input  logic              cmd_empty,
   input  logic [WORD_W-1:0] cmd_dout,
   output logic              cmd_pop,
   input  logic              pld_empty,
   input  logic [WORD_W-1:0] pld_dout,
   output logic              pld_pop,
   output logic              lk_valid,
   input  logic              lk_ready,
   output logic [WORD_W-1:0] lk_data,
   output logic              lk_last,
   output logic              lk_lp,
   output logic              lk_ack,
   output logic              rd_sent
);
   tx_state_e         state_q;
   logic [WORD_W-1:0] hdr_q;
   logic [REM_W-1:0]  rem_q;
   logic              lp_q, ack_q;

   logic [WC_W:0]     wc_sum;
   logic [REM_W-1:0]  wc_words;

   assign wc_sum   = {1'b0, cmd_dout[8 +: WC_W]} + (WC_W + 1)'(3);
   assign wc_words = wc_sum[WC_W:2];

   always_comb begin
      cmd_pop  = 1'b0;
      pld_pop  = 1'b0;
      lk_valid = 1'b0;
      lk_data  = hdr_q;
      lk_last  = 1'b0;
      rd_sent  = 1'b0;
      case (state_q)
         TX_IDLE: cmd_pop = !cmd_empty;
         TX_HDR: begin
            lk_valid = 1'b1;
            lk_last  = (rem_q == '0);
            rd_sent  = lk_ready && (rem_q == '0) && is_read(hdr_q[5:0]);
         end
         TX_PLD: begin
            lk_valid = !pld_empty;
            lk_data  = pld_dout;
            lk_last  = (rem_q == REM_W'(1));
            pld_pop  = !pld_empty && lk_ready;
         end
         default: ;
      endcase
   end

   assign lk_lp  = lp_q;
   assign lk_ack = ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         hdr_q   <= '0;
         rem_q   <= '0;
         lp_q    <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         case (state_q)
            TX_IDLE: if (!cmd_empty) begin
               hdr_q   <= cmd_dout;
               rem_q   <= is_long(cmd_dout[5:0]) ? wc_words : '0;
               lp_q    <= lp_pick(cmd_dout[5:0], cfg);
               ack_q   <= cfg[CFG_ACK];
               state_q <= TX_HDR;
            end
            TX_HDR: if (lk_ready) state_q <= (rem_q == '0) ? TX_IDLE : TX_PLD;
            TX_PLD: if (pld_pop) begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == REM_W'(1)) state_q <= TX_IDLE;
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   // R4: a stalled word is held
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !lk_ready |=> lk_valid && $stable(lk_data) && $stable(lk_last));
   // R5: the final word closes the packet, the next cycle is idle
   p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_ready && lk_last |=> !lk_valid);
   // R7, R8: the mode flags stay fixed within a packet
   p_flags_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !lk_last |=> $stable(lk_lp) && $stable(lk_ack));
endmodule

// File: rtl/cpf_cmd_if.sv
module cpf_cmd_if import cpf_pkg::*; #(
   parameter int CMD_DEPTH = 4,
   parameter int WR_DEPTH  = 8,
   parameter int RD_DEPTH  = 4,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              lk_valid,
   input  logic              lk_ready,
   output logic [31:0]       lk_data,
   output logic              lk_last,
   output logic              lk_lp,
   output logic              lk_ack,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [31:0]       rsp_data,
   input  logic              rsp_last
);
   initial begin
      assert (ADDR_W >= 4) else $error("cpf_cmd_if: ADDR_W must be at least 4");
   end

   logic sel_cfg, sel_hdr, sel_pld, sel_stat;
   assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
   assign sel_hdr  = (bus_addr == ADDR_W'(OFS_HDR));
   assign sel_pld  = (bus_addr == ADDR_W'(OFS_PLD));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

   logic [WORD_W-1:0] cfg_q;
   logic              ovf_q, busy_q;

   logic              cmd_empty, cmd_full, cmd_push, cmd_pop;
   logic [WORD_W-1:0] cmd_dout;
   logic              wr_empty, wr_full, wr_push, wr_pop;
   logic [WORD_W-1:0] wr_dout;
   logic              rd_empty, rd_full, rd_push, rd_pop;
   logic [WORD_W-1:0] rd_dout;
   logic              rd_sent, drop, clr_ovf;

   assign cmd_push  = bus_wr && sel_hdr && !cmd_full;
   assign wr_push   = bus_wr && sel_pld && !wr_full;
   assign drop      = bus_wr && ((sel_hdr && cmd_full) || (sel_pld && wr_full));
   assign clr_ovf   = bus_wr && sel_stat && bus_wdata[ST_OVF];
   assign rsp_ready = !rd_full;
   assign rd_push   = rsp_valid && !rd_full;
   assign rd_pop    = bus_rd && sel_pld && !rd_empty;

   cpf_fifo #(.DEPTH(CMD_DEPTH), .W(WORD_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(bus_wdata), .pop(cmd_pop),
      .dout(cmd_dout), .empty(cmd_empty), .full(cmd_full));

   cpf_fifo #(.DEPTH(WR_DEPTH), .W(WORD_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .push(wr_push), .din(bus_wdata), .pop(wr_pop),
      .dout(wr_dout), .empty(wr_empty), .full(wr_full));

   cpf_fifo #(.DEPTH(RD_DEPTH), .W(WORD_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .push(rd_push), .din(rsp_data), .pop(rd_pop),
      .dout(rd_dout), .empty(rd_empty), .full(rd_full));

   cpf_tx_engine u_tx (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
      .cmd_empty(cmd_empty), .cmd_dout(cmd_dout), .cmd_pop(cmd_pop),
      .pld_empty(wr_empty), .pld_dout(wr_dout), .pld_pop(wr_pop),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_data(lk_data),
      .lk_last(lk_last), .lk_lp(lk_lp), .lk_ack(lk_ack), .rd_sent(rd_sent));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ovf_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (bus_wr && sel_cfg) cfg_q <= bus_wdata & CFG_MASK;
         if (drop) ovf_q <= 1'b1;
         else if (clr_ovf) ovf_q <= 1'b0;
         if (rd_sent) busy_q <= 1'b1;
         else if (rd_push && rsp_last) busy_q <= 1'b0;
      end
   end

   logic [WORD_W-1:0] status;
   assign status = {24'b0, ovf_q, busy_q, rd_full, rd_empty,
                    wr_full, wr_empty, cmd_full, cmd_empty};

   always_comb begin
      bus_rdata = '0;
      if (sel_cfg)       bus_rdata = cfg_q;
      else if (sel_stat) bus_rdata = status;
      else if (sel_pld)  bus_rdata = rd_empty ? '0 : rd_dout;
   end

   // R9: the read flag rises only after a packet end was accepted
   p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(lk_valid && lk_ready && lk_last));
   // R9: it falls only on an accepted final response word
   p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(rsp_valid && rsp_ready && rsp_last));
   // R6: the overflow flag holds until cleared
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !clr_ovf |=> ovf_q);
   // R11: with nothing queued or in flight, the link stays quiet
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_empty && !lk_valid && !$past(cmd_push) |=> !lk_valid);
endmodule

// File: tb/sim_cpf_cmd_if.sv
module sim_cpf_cmd_if;
   localparam int CMD_D = 4;
   localparam int WR_D  = 8;
   localparam int RD_D  = 4;
   localparam logic [31:0] MASK = 32'h010F_7F02;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        lk_valid, lk_last, lk_lp, lk_ack;
   logic        lk_ready = 1'b0;
   logic [31:0] lk_data;
   logic        rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
   logic [31:0] rsp_data = '0;

   always #4 clk = ~clk;

   cpf_cmd_if #(.CMD_DEPTH(CMD_D), .WR_DEPTH(WR_D), .RD_DEPTH(RD_D), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_valid(lk_valid),
      .lk_ready(lk_ready), .lk_data(lk_data), .lk_last(lk_last), .lk_lp(lk_lp),
      .lk_ack(lk_ack), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_last(rsp_last));

   int n_chk = 0, n_fail = 0;
   int rdy_mode = 1;
   logic [31:0] cfg_cur = '0;

   logic [31:0] cap_d[$], exp_d[$];
   logic [2:0]  cap_f[$], exp_f[$];
   bit          stall_pend = 0;
   logic [31:0] stall_d;
   logic        stall_l;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic exp_lp(input logic [5:0] dt, input logic [31:0] c);
      case (dt)
         6'h03: return c[8];   6'h13: return c[9];   6'h23: return c[10];
         6'h04: return c[11];  6'h14: return c[12];  6'h24: return c[13];
         6'h29: return c[14];  6'h05: return c[16];  6'h15: return c[17];
         6'h06: return c[18];  6'h39: return c[19];  6'h37: return c[24];
         default: return 1'b0;
      endcase
   endfunction

   // link sink: ready chosen at the falling edge, handshake sampled just after
   always @(negedge clk) begin
      if (rst_n) begin
         case (rdy_mode)
            0: lk_ready = ($urandom % 3) != 0;
            1: lk_ready = 1'b0;
            default: lk_ready = 1'b1;
         endcase
         #1;
         if (stall_pend)
            chk(lk_valid && lk_data == stall_d && lk_last == stall_l, "R4 stalled word held",
                lk_data, stall_d);
         stall_pend = lk_valid && !lk_ready;
         stall_d = lk_data;
         stall_l = lk_last;
         if (lk_valid && lk_ready) begin
            cap_d.push_back(lk_data);
            cap_f.push_back({lk_last, lk_lp, lk_ack});
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 4'h0) cfg_cur = d & MASK;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #2 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string req);
      logic [31:0] v;
      rd(a, v);
      chk(v == e, req, v, e);
   endtask

   task automatic rsp(input logic [31:0] d, input logic l);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = d; rsp_last = l;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_last = 1'b0;
   endtask

   task automatic expect_pkt(input logic [31:0] hdr, input int nw, input logic [31:0] w[16]);
      logic lp, ak;
      lp = exp_lp(hdr[5:0], cfg_cur);
      ak = cfg_cur[1];
      exp_d.push_back(hdr);
      exp_f.push_back({nw == 0, lp, ak});
      for (int i = 0; i < nw; i++) begin
         exp_d.push_back(w[i]);
         exp_f.push_back({i == nw - 1, lp, ak});
      end
   endtask

   task automatic check_stream(input string req);
      int t = 0;
      while (cap_d.size() < exp_d.size() && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      chk(cap_d.size() == exp_d.size(), {req, " word count"}, cap_d.size(), exp_d.size());
      if (cap_d.size() == exp_d.size())
         for (int i = 0; i < exp_d.size(); i++) begin
            chk(cap_d[i] == exp_d[i], {req, " word"}, cap_d[i], exp_d[i]);
            chk(cap_f[i] == exp_f[i], {req, " R7 R8 last/lp/ack"}, 32'(cap_f[i]), 32'(exp_f[i]));
         end
      cap_d.delete(); cap_f.delete(); exp_d.delete(); exp_f.delete();
   endtask

   // long packet: payload first, header last
   task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vc, input int len,
                           input logic [15:0] prm);
      logic [7:0]  b[64];
      logic [31:0] w[16];
      logic [31:0] hdr;
      int nw;
      nw = 0;
      if (dt[3:0] == 4'h9) begin
         for (int i = 0; i < 64; i++) b[i] = (i < len) ? 8'($urandom) : 8'h00;
         nw = (len + 3) / 4;
         for (int k = 0; k < 16; k++) w[k] = {b[4*k+3], b[4*k+2], b[4*k+1], b[4*k]};
         for (int k = 0; k < nw; k++) wr(4'h8, w[k]);
         hdr = {8'h00, 16'(len), vc, dt};
      end else begin
         for (int k = 0; k < 16; k++) w[k] = '0;
         hdr = {8'h00, prm, vc, dt};
      end
      expect_pkt(hdr, nw, w);
      wr(4'h4, hdr);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] w[16];
      logic [31:0] v;
      logic [5:0]  types[9];
      void'($urandom(32'd2024));
      types = '{6'h29, 6'h39, 6'h19, 6'h03, 6'h13, 6'h23, 6'h05, 6'h15, 6'h37};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1 chk(lk_valid == 1'b0, "R1 link idle after reset", lk_valid, 0);

      rd_chk(4'hC, 32'h15, "R1 R2 status after reset");
      rd_chk(4'h0, 32'h0, "R1 configuration after reset");
      wr(4'h0, 32'hFFFF_FFFF);
      rd_chk(4'h0, MASK, "R7 writable configuration bits");

      // stale payload word, then a short packet that must not consume it
      rdy_mode = 2;
      wr(4'h8, 32'hA5A5_A5A5);
      repeat (10) @(negedge clk);
      chk(cap_d.size() == 0, "R3 nothing sent before header", cap_d.size(), 0);
      for (int k = 0; k < 16; k++) w[k] = '0;
      expect_pkt(32'h0012_3405, 0, w);
      wr(4'h4, 32'h0012_3405);
      check_stream("R5 short packet");
      rd_chk(4'hC, 32'h11, "R5 short packet leaves payload queued");
      w[0] = 32'hA5A5_A5A5;
      expect_pkt(32'h0000_0429, 1, w);
      wr(4'h4, 32'h0000_0429);
      check_stream("R3 R5 long packet takes queued word");
      rd_chk(4'hC, 32'h15, "R11 both FIFOs empty after send");

      // random packets under random back-pressure
      rdy_mode = 0;
      for (int it = 0; it < 40; it++) begin
         if (it % 10 == 0) wr(4'h0, $urandom);
         send_pkt(types[$urandom % 9], 2'($urandom), $urandom % 14, 16'($urandom));
         check_stream("R3 R5 random packet");
         rd_chk(4'hC, 32'h15, "R11 empty after random packet");
      end
      // zero-length long packet
      send_pkt(6'h39, 2'd1, 0, 16'h0);
      check_stream("R5 zero-length long packet");

      // payload overflow
      rdy_mode = 1;
      for (int i = 0; i <= WR_D; i++) wr(4'h8, 32'h1000_0000 + 32'(i));
      rd_chk(4'hC, 32'h99, "R6 payload FIFO full and overflow flagged");
      for (int i = 0; i < 16; i++) w[i] = 32'h1000_0000 + 32'(i);
      expect_pkt({8'h00, 16'(4 * WR_D), 8'h29}, WR_D, w);
      wr(4'h4, {8'h00, 16'(4 * WR_D), 8'h29});
      rdy_mode = 2;
      check_stream("R6 dropped payload word absent");
      rd_chk(4'hC, 32'h95, "R6 overflow flag sticky");
      wr(4'hC, 32'h80);
      rd_chk(4'hC, 32'h15, "R6 overflow flag cleared");

      // header overflow: transmitter holds one, FIFO holds CMD_D, one dropped
      rdy_mode = 1;
      for (int k = 0; k < 16; k++) w[k] = '0;
      for (int i = 0; i < CMD_D + 2; i++) begin
         if (i < CMD_D + 1) expect_pkt({8'h00, 16'(i), 8'h03}, 0, w);
         wr(4'h4, {8'h00, 16'(i), 8'h03});
      end
      rd_chk(4'hC, 32'h96, "R6 command FIFO full and overflow flagged");
      rdy_mode = 2;
      check_stream("R6 dropped header absent");
      wr(4'hC, 32'h80);
      rd_chk(4'hC, 32'h15, "R6 R11 clean after header overflow");

      // read request and response
      send_pkt(6'h14, 2'd0, 0, 16'h0055);
      check_stream("R9 read request sent");
      rd_chk(4'hC, 32'h55, "R9 read in progress set");
      rsp(32'h4433_2211, 1'b0);
      rd_chk(4'hC, 32'h45, "R9 busy held before final word");
      rsp(32'h8877_6655, 1'b1);
      rd_chk(4'hC, 32'h05, "R9 busy cleared by final word");
      rd_chk(4'h8, 32'h4433_2211, "R10 first response word");
      rd_chk(4'h8, 32'h8877_6655, "R10 second response word");
      rd_chk(4'h8, 32'h0, "R10 empty read returns zero");
      rd_chk(4'hC, 32'h15, "R10 read FIFO empty again");

      // read FIFO full with a final word refused
      send_pkt(6'h06, 2'd2, 0, 16'h00DA);
      check_stream("R9 DCS read request sent");
      for (int i = 0; i < RD_D; i++) rsp(32'hC000_0000 + 32'(i), 1'b0);
      rd_chk(4'hC, 32'h65, "R10 read FIFO full");
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 32'hDEAD_0001; rsp_last = 1'b1;
      #1 chk(rsp_ready == 1'b0, "R10 rsp_ready low when full", rsp_ready, 0);
      repeat (3) @(negedge clk);
      rsp_valid = 1'b0; rsp_last = 1'b0;
      rd_chk(4'hC, 32'h65, "R9 R10 refused final word changes nothing");
      for (int i = 0; i < RD_D; i++) rd_chk(4'h8, 32'hC000_0000 + 32'(i), "R10 drain order");
      rsp(32'hDEAD_0001, 1'b1);
      rd_chk(4'hC, 32'h05, "R9 busy cleared after retry");
      rd_chk(4'h8, 32'hDEAD_0001, "R10 retried word stored");
      rd_chk(4'hC, 32'h15, "R1 R11 all idle at end");

      finish_run();
   end
endmodule